// File: doc/BRIEF.md
# Graphics Overlay Register File with Write-Merge

This block holds the byte-wide I/O registers of a bitmap graphics add-on that works beside a display controller. A CPU reaches it through a small strobed bus with a 3-bit port offset. Six offsets are decoded. Behind them sit a control byte that can be read back, an indirect select register, a mode register, a 16-bit write mask loaded one byte at a time, and a 256 x 8 scroll map. The scroll map is reached through one data port whose index advances by itself after each access.

The block also has a purely combinational merge path. The video memory read-modify-write cycle uses it to decide, bit by bit, whether each bit of a 16-bit word takes the new pixel data or keeps the existing memory contents. The mode register selects the merge rule. In mask mode the stored write mask chooses. In vector mode a pattern word supplied with the data chooses.

Top module: `gfx_overlay_regs`

## Requirements
- R1: A cycle with `rst_n` low at a clock edge clears the control byte, the select register, the mode register, the write mask, the read data output and the scroll index to zero. Scroll map contents are kept.
- R2: A write to offset 0 stores the byte. A read at offset 0 returns the last byte stored there. Read data appears on `bus_rdata` at the clock edge that samples the read strobe and holds until the next read.
- R3: A write to offset 0 with bit 0 set also clears the select register, the mode register and the write mask, but not the scroll index. A write to offset 0 with bit 0 clear changes nothing but the control byte.
- R4: A write to offset 4 loads the byte, bit-reversed (bit 0 lands in mask bit 15), into mask bits 15..8 and leaves bits 7..0 unchanged.
- R5: A write to offset 5 loads the byte, bit-reversed (bit 0 lands in mask bit 7), into mask bits 7..0 and leaves bits 15..8 unchanged.
- R6: When mode bit 0 is clear, `pix_merged` = (`pix_new` AND NOT mask) OR (`pix_old` AND mask), with no clock delay.
- R7: When mode bit 0 is set, `pix_merged` = (`pix_new` AND NOT `pix_pattern`) OR (`pix_old` AND `pix_pattern`).
- R8: A write at offset 1 while select bit 7 is set stores the byte into the scroll map at the current index and advances the index. The index wraps from 255 to 0.
- R9: A read at offset 1 while select bit 7 is set returns the scroll map entry at the current index and advances the index, with the same wrap.
- R10: A read at offsets 2 to 5, and a read or write at offset 1 while select bit 7 is clear, return 0x00 (reads) and change no state. In particular the scroll index does not move.
- R11: A write to offset 3 loads the select register. A write to offset 2 loads the mode register, whose bit 0 is the vector-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 3 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pix_new | input | 16 | New pixel word |
| pix_old | input | 16 | Existing video memory word |
| pix_pattern | input | 16 | Pattern word used in vector mode |
| pix_merged | output | 16 | Merged word to write back |

## Verification
A wrong mask byte or wrong bit order shows on `pix_merged` in the same cycle that the write lands, so each mask load is followed at once by merges with complementary new and old words. A scroll index that slips or skips by one shows on the very next data-port read as the entry of a neighbouring slot. The map is filled with distinct values so that such a shift can always be seen. A soft reset that clears too much or too little shows in the next control read-back, in a merge that falls back to pass-through, or in a data-port read that returns zero or an unexpected index.

// File: rtl/gfx_ovl_pkg.sv
// Package: shared widths and port offsets for the graphics overlay register file.
// Assumes the write mask is exactly two bus bytes wide.
package gfx_ovl_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int OFS_W     = 3;
    localparam int MAP_DEPTH = 256;

    // Port offsets (decoded positions are behaviour, so they are fixed here)
    localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd0;
    localparam logic [OFS_W-1:0] OFS_DATA    = 3'd1;
    localparam logic [OFS_W-1:0] OFS_MODE    = 3'd2;
    localparam logic [OFS_W-1:0] OFS_SELECT  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_MASK_HI = 3'd4;
    localparam logic [OFS_W-1:0] OFS_MASK_LO = 3'd5;

    // Bit positions
    localparam int SRST_BIT    = 0;   // soft reset trigger in control write
    localparam int MAP_SEL_BIT = 7;   // select register: data port targets scroll map
    localparam int VEC_BIT     = 0;   // mode register: vector merge
endpackage

// File: rtl/gfx_ovl_ctrl_regs.sv
// Module: control, select, mode and write-mask registers.
// Does:    loads the registers from bus writes; a control write with the
//          soft-reset bit set clears select, mode and mask first. Mask bytes
//          are stored bit-reversed into the half chosen by the offset.
// Assumes: one write per cycle; WORD_W == 2*BYTE_W.
module gfx_ovl_ctrl_regs
    import gfx_ovl_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int WW = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [BW-1:0]   wdata,
    output logic [BW-1:0]   ctrl_q,
    output logic [BW-1:0]   select_q,
    output logic [BW-1:0]   mode_q,
    output logic [WW-1:0]   mask_q
);
    localparam int HALF = WW / 2;

    logic [BW-1:0] wdata_rev;

    // Bit-reverse the incoming byte for the mask halves
    for (genvar i = 0; i < BW; i++) begin : g_rev
        assign wdata_rev[i] = wdata[BW-1-i];
    end

    // Register update: external reset, soft reset and per-offset loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            select_q <= '0;
            mode_q   <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_CTRL: begin
                    if (wdata[SRST_BIT]) begin
                        select_q <= '0;
                        mode_q   <= '0;
                        mask_q   <= '0;
                    end
                    ctrl_q <= wdata;
                end
                OFS_MODE:    mode_q   <= wdata;
                OFS_SELECT:  select_q <= wdata;
                OFS_MASK_HI: mask_q[WW-1:HALF] <= wdata_rev;
                OFS_MASK_LO: mask_q[HALF-1:0]  <= wdata_rev;
                default: ;
            endcase
        end
    end

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_CTRL && wdata[SRST_BIT]) |=>
        (select_q == '0 && mode_q == '0 && mask_q == '0)); // R3
    AST_CTRL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_CTRL && !wdata[SRST_BIT]) |=>
        ($stable(select_q) && $stable(mode_q) && $stable(mask_q))); // R3
    AST_MASK_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_MASK_HI) |=> $stable(mask_q[HALF-1:0])); // R4
    AST_MASK_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_MASK_LO) |=> $stable(mask_q[WW-1:HALF])); // R5
endmodule

// File: rtl/gfx_ovl_scroll_map.sv
// Module: scroll map storage with an auto-advancing index.
// Does:    every access (read or write) advances the index by one, wrapping
//          at the last entry; writes store at the current index.
// Assumes: caller asserts acc only for accesses that target the map.
//          Contents are not reset; only the index is.
module gfx_ovl_scroll_map
    import gfx_ovl_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int DEPTH = MAP_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rd_byte
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [BW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] idx;

    // Storage write at the current index
    always_ff @(posedge clk) begin
        if (acc && wr) begin
            mem[idx] <= wdata;
        end
    end

    // Index advance with wrap; cleared only by external reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (acc) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    assign rd_byte = mem[idx];

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && idx == LAST) |=> (idx == '0)); // R8
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && idx != LAST) |=> (idx == $past(idx) + 1'b1)); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(idx)); // R10
endmodule

// File: rtl/gfx_ovl_merge.sv
// Module: combinational read-modify-write merge.
// Does:    for each bit picks the existing word when the chooser bit is 1,
//          else the new word; chooser is the mask (mask mode) or the
//          pattern (vector mode).
// Assumes: inputs are stable for the combinational path's use.
module gfx_ovl_merge
    import gfx_ovl_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          vec_mode,
    input  logic [WW-1:0] mask,
    input  logic [WW-1:0] pattern,
    input  logic [WW-1:0] new_word,
    input  logic [WW-1:0] old_word,
    output logic [WW-1:0] merged
);
    for (genvar i = 0; i < WW; i++) begin : g_bit
        logic keep_old;
        // Per-bit chooser and select
        assign keep_old  = vec_mode ? pattern[i] : mask[i];
        assign merged[i] = keep_old ? old_word[i] : new_word[i];
    end
endmodule

// File: rtl/gfx_overlay_regs.sv
// Module: top of the graphics overlay register file and write-merge unit.
// Does:    decodes bus accesses to the control registers and the scroll
//          map port, registers read data, and exposes the word merge.
// Assumes: synchronous active-low reset; one bus access per cycle.
module gfx_overlay_regs
    import gfx_ovl_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int WW    = WORD_W,
    parameter int DEPTH = MAP_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_ofs,
    input  logic [BW-1:0]    bus_wdata,
    output logic [BW-1:0]    bus_rdata,
    input  logic [WW-1:0]    pix_new,
    input  logic [WW-1:0]    pix_old,
    input  logic [WW-1:0]    pix_pattern,
    output logic [WW-1:0]    pix_merged
);
    logic          wr_acc;
    logic          rd_acc;
    logic          map_acc;
    logic [BW-1:0] ctrl_q;
    logic [BW-1:0] select_q;
    logic [BW-1:0] mode_q;
    logic [WW-1:0] mask_q;
    logic [BW-1:0] map_byte;

    // Access decode
    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign map_acc = bus_sel && (bus_ofs == OFS_DATA) && select_q[MAP_SEL_BIT];

    gfx_ovl_ctrl_regs #(.BW(BW), .WW(WW)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_acc),
        .ofs      (bus_ofs),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .select_q (select_q),
        .mode_q   (mode_q),
        .mask_q   (mask_q)
    );

    gfx_ovl_scroll_map #(.BW(BW), .DEPTH(DEPTH)) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (map_acc),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .rd_byte (map_byte)
    );

    gfx_ovl_merge #(.WW(WW)) i_merge (
        .vec_mode (mode_q[VEC_BIT]),
        .mask     (mask_q),
        .pattern  (pix_pattern),
        .new_word (pix_new),
        .old_word (pix_old),
        .merged   (pix_merged)
    );

    // Registered read data, updated only on a read access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_acc) begin
            if (bus_ofs == OFS_CTRL) begin
                bus_rdata <= ctrl_q;
            end else if (map_acc) begin
                bus_rdata <= map_byte;
            end else begin
                bus_rdata <= '0;
            end
        end
    end

    AST_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_ofs >= OFS_MODE && bus_ofs <= OFS_MASK_LO) |=>
        (bus_rdata == '0)); // R10
    AST_CTRL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_ofs == OFS_CTRL) |=> (bus_rdata == $past(ctrl_q))); // R2
    AST_MERGE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[VEC_BIT] |->
        ((((pix_merged ^ pix_old) & mask_q) == '0) &&
         (((pix_merged ^ pix_new) & ~mask_q) == '0))); // R6
    AST_MERGE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[VEC_BIT] |->
        ((((pix_merged ^ pix_old) & pix_pattern) == '0) &&
         (((pix_merged ^ pix_new) & ~pix_pattern) == '0))); // R7
endmodule

// File: tb/test_gfx_overlay_regs.sv
module test_gfx_overlay_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_ofs = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pix_new = '0;
    logic [15:0] pix_old = '0;
    logic [15:0] pix_pattern = '0;
    logic [15:0] pix_merged;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic saw_rd = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gfx_overlay_regs i_gfx_overlay_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_new(pix_new), .pix_old(pix_old), .pix_pattern(pix_pattern),
        .pix_merged(pix_merged)
    );

    // Monitor: note a read at the edge, compare registered data at next negedge
    always @(posedge clk) saw_rd <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (saw_rd) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read result with no expected item");
            end else begin
                e = exp_q.pop_front();
                checks++;
                if (bus_rdata !== e.val) begin
                    errors++;
                    $display("FAIL %s: rdata actual %02h expected %02h", e.tag, bus_rdata, e.val);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ofs, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = ofs;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic merge(input logic [15:0] n, input logic [15:0] o,
                         input logic [15:0] p, input logic [15:0] exp, input string tag);
        @(negedge clk);
        pix_new = n; pix_old = o; pix_pattern = p;
        #1;
        checks++;
        if (pix_merged !== exp) begin
            errors++;
            $display("FAIL %s: merged actual %04h expected %04h", tag, pix_merged, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(3'd0, 8'h00, "R1 ctrl after reset");
        merge(16'hA5A5, 16'h0F0F, 16'hFFFF, 16'hA5A5, "R1 mask zero passes new");
        // R2: control store and read-back
        wr(3'd0, 8'h42);
        rd(3'd0, 8'h42, "R2 ctrl readback");
        // R11: mode and select loads; R4/R5 mask loads
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h80);
        wr(3'd4, 8'h01);                 // upper = 0x80 -> mask 8000
        wr(3'd5, 8'h03);                 // lower = 0xC0 -> mask 80C0
        merge(16'hFFFF, 16'h0000, 16'h00F0, 16'hFF0F, "R7 vector merge");
        merge(16'h1234, 16'hABCD, 16'hFF00, 16'hAB34, "R7 vector merge second");
        wr(3'd2, 8'h00);
        merge(16'hFFFF, 16'h0000, 16'h00F0, 16'h7F3F, "R6 R11 masked merge, R4 R5 reversal");
        merge(16'h0000, 16'hFFFF, 16'h0000, 16'h80C0, "R6 masked merge keeps old");
        wr(3'd4, 8'h00);                 // mask 00C0
        merge(16'hFFFF, 16'h0000, 16'h0000, 16'hFF3F, "R4 upper load keeps lower");
        wr(3'd5, 8'h80);                 // mask 0001
        merge(16'hFFFF, 16'h0000, 16'h0000, 16'hFFFE, "R5 lower load keeps upper");
        merge(16'hABCD, 16'h1234, 16'h0000, 16'hABCC, "R6 masked merge mixed");
        // R8: fill map, index wraps to 0
        for (int i = 0; i < 256; i++) wr(3'd1, 8'(i) ^ 8'h5A);
        // R9: read all entries back from wrapped index 0
        for (int i = 0; i < 256; i++) rd(3'd1, 8'(i) ^ 8'h5A, "R8 R9 map entry");
        rd(3'd1, 8'h5A, "R9 read index wrapped to 0");   // index now 1
        // R10: quiet reads
        rd(3'd2, 8'h00, "R10 offset 2 read");
        rd(3'd3, 8'h00, "R10 offset 3 read");
        rd(3'd4, 8'h00, "R10 offset 4 read");
        rd(3'd5, 8'h00, "R10 offset 5 read");
        rd(3'd1, 8'h5B, "R10 index unchanged by quiet reads");  // index now 2
        wr(3'd3, 8'h00);
        rd(3'd1, 8'h00, "R10 data read with map unselected");
        wr(3'd1, 8'hEE);                 // ignored
        wr(3'd3, 8'h80);
        rd(3'd1, 8'h58, "R10 index and map unchanged while unselected");  // index 3
        rd(3'd0, 8'h42, "R10 ctrl unchanged");
        // R3: bit-0-clear write only stores; bit-0-set soft reset
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h40);
        rd(3'd0, 8'h40, "R3 plain ctrl write stores");
        merge(16'hFFFF, 16'h0000, 16'h0F0F, 16'hF0F0, "R3 plain ctrl write keeps mode");
        wr(3'd0, 8'h43);
        rd(3'd0, 8'h43, "R3 soft reset stores byte");
        merge(16'h1357, 16'hFFFF, 16'hFFFF, 16'h1357, "R3 soft reset clears mode and mask");
        rd(3'd1, 8'h00, "R3 soft reset clears select");
        wr(3'd3, 8'h80);
        rd(3'd1, 8'h59, "R3 soft reset keeps scroll index");  // index 4
        // R1: external reset clears index, keeps map
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(3'd0, 8'h00, "R1 ctrl cleared by reset");
        rd(3'd1, 8'h00, "R1 select cleared by reset");
        wr(3'd3, 8'h80);
        rd(3'd1, 8'h5A, "R1 index cleared by reset");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads never answered, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule